// File: doc/BRIEF.md
# Battery-Low Check Sequencer

This block is a host-side master for a serial multi-channel converter. The converter's interface has three lines: an active-low frame strobe, a serial clock, and one bidirectional data line. A single `go` pulse makes the block run a complete battery check. It first writes the converter's control bits so that the internal bandgap reference is on and the weak pull-down is selected. It then switches the battery channel to analog and reads that channel up to three times. When the check is over, it restores the reference selection and returns the channel to digital mode.

The decision looks only at the most significant result bit. Any reading of 128 or more ends the check at once with the battery declared healthy. The flag `battery_low` is raised only when the configured number of consecutive readings (three by default) are all below 128. The flag keeps its value until the next `go`. A one-cycle `done` pulse marks the end of the restore frames. The caller's attribute mask supplies the analog/digital mode of the other seven channels in both attribute writes.

Top module: `batt_probe_seq`

## Requirements
- R1: While reset is held, and after it, the block keeps `frame_n_o` high, `sclk_o` low, `dio_oe` low, `done` low and `battery_low` low.
- R2: In every frame, `frame_n_o` goes low and `sclk_o` gives one rising edge per bit. The 3-bit opcode is sent MSB first, followed by the payload, and then `frame_n_o` goes high. `sclk_o` stays low whenever `frame_n_o` is high.
- R3: The first frame is a control write of 7 clocks: opcode 011, then the mode bits in the order pull-up, pull-down, bandgap-on, pin-reference = 0,1,1,0.
- R4: The second frame is an attribute write of 11 clocks: opcode 001, then eight bits for channels 7 down to 0 (1 = analog). Channel 7 is forced to 1, and channels 6..0 come from `attr_mask[6:0]`.
- R5: A conversion frame has 16 clocks. The host sends opcode 100 and channel bits 111, releases the line for two clocks, and then captures eight result bits, MSB first, during the high phase of `sclk_o`.
- R6: A reading with bit 7 set ends the reads and leaves `battery_low` at 0. No further conversion frame follows it.
- R7: When the configured number of consecutive readings (3) all have bit 7 clear, `battery_low` becomes 1, and exactly that many conversion frames are sent.
- R8: After the reads, the block sends a control write of 011 with bits 0,1,0,0. It then sends an attribute write of 001 with channel 7 = 0 and channels 6..0 from the mask. Bit 7 of the mask is ignored in both attribute writes.
- R9: `done` is high for exactly one cycle after the last restore frame has closed. `battery_low` then holds its value until the next accepted `go`, which clears it.
- R10: `dio_oe` falls at the falling clock edge that ends the last bit the host sends. It stays low until the frame strobe rises and is never high while `frame_n_o` is high.
- R11: The serial clock period is 2*DIV_HALF system clocks.
- R12: A `go` that arrives while a check is running is ignored. The running check keeps its frames and its original mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle request to run a check |
| attr_mask | input | 8 | Channel mode mask (1 = analog); bit 7 is overridden |
| done | output | 1 | One-cycle pulse at the end of a check |
| battery_low | output | 1 | Result of the last check |
| sclk_o | output | 1 | Serial clock to the converter |
| frame_n_o | output | 1 | Active-low frame strobe |
| dio_out | output | 1 | Data driven by the host |
| dio_oe | output | 1 | Output enable for `dio_out` |
| dio_in | input | 1 | Data returned by the converter |

## Verification
The bound checker checks the following on every cycle:
- the serial clock stays idle and the data line is released whenever the strobe is high;
- `done` lasts a single cycle and comes only with the strobe high;
- the flag changes only during a run or on an accepted `go`;
- every edge of the serial clock follows a divider tick.

Some behaviour shows up only in the bench's converter model. That model records the bit stream of each frame and returns scripted readings. From those records the bench checks the opcodes and payloads, the channel-7 override, the turnaround timing, the MSB-only decision, the count of conversion reads for each reading pattern, and the handling of a `go` during a run.

// File: rtl/bl_pkg.sv
package bl_pkg;

   localparam logic [2:0] OP_CTRL = 3'b011;
   localparam logic [2:0] OP_ATTR = 3'b001;
   localparam logic [2:0] OP_CONV = 3'b100;

   localparam int TX_W = 11;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CFG_ON,
      SQ_MODE_ON,
      SQ_SAMPLE,
      SQ_CFG_OFF,
      SQ_MODE_OFF
   } sq_state_t;

   typedef enum logic [1:0] {
      FE_IDLE,
      FE_LEAD,
      FE_CLK,
      FE_TAIL
   } fe_state_t;

   typedef struct packed {
      logic [TX_W-1:0] tx_word;
      logic [3:0]      tx_bits;
      logic [1:0]      gap_clks;
      logic [3:0]      rx_bits;
   } frame_desc_t;

endpackage

// File: rtl/bl_tick_gen.sv
module bl_tick_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (DIV_HALF < 1) begin : g_bad_div
      $error("bl_tick_gen: DIV_HALF must be at least 1");
   end

   if (DIV_HALF == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!run) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = run && (cnt_q == LAST);
   end
endmodule

// File: rtl/bl_frame_engine.sv
module bl_frame_engine
   import bl_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        start,
   input  frame_desc_t desc,
   output logic        busy,
   output logic        fdone,
   output logic        rx_msb,
   output logic        sclk,
   output logic        frame_n,
   output logic        dio_out,
   output logic        dio_oe,
   input  logic        dio_in
);
   if (RES_W < 2 || RES_W > 15) begin : g_bad_res
      $error("bl_frame_engine: RES_W must lie in 2..15");
   end

   fe_state_t        st_q;
   logic [TX_W-1:0]  sh_q;
   logic [4:0]       tx_n_q;
   logic [4:0]       tot_q;
   logic [4:0]       rx_from_q;
   logic [4:0]       idx_q;
   logic [4:0]       idx_nx;
   logic [RES_W-1:0] rx_q;
   logic             sclk_q;
   logic             frame_q;
   logic             oe_q;
   logic             fdone_q;

   assign idx_nx = idx_q + 5'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FE_IDLE;
         sh_q      <= '0;
         tx_n_q    <= '0;
         tot_q     <= '0;
         rx_from_q <= '0;
         idx_q     <= '0;
         rx_q      <= '0;
         sclk_q    <= 1'b0;
         frame_q   <= 1'b1;
         oe_q      <= 1'b0;
         fdone_q   <= 1'b0;
      end else begin
         fdone_q <= 1'b0;
         case (st_q)
            FE_IDLE: begin
               if (start) begin
                  st_q      <= FE_LEAD;
                  sh_q      <= desc.tx_word;
                  tx_n_q    <= {1'b0, desc.tx_bits};
                  tot_q     <= {1'b0, desc.tx_bits} + {3'b000, desc.gap_clks}
                               + {1'b0, desc.rx_bits};
                  rx_from_q <= {1'b0, desc.tx_bits} + {3'b000, desc.gap_clks};
                  idx_q     <= '0;
                  rx_q      <= '0;
                  frame_q   <= 1'b0;
                  oe_q      <= (desc.tx_bits != 4'd0);
               end
            end
            FE_LEAD: begin
               if (tick) begin
                  st_q   <= FE_CLK;
                  sclk_q <= 1'b1;
               end
            end
            FE_CLK: begin
               if (tick) begin
                  if (sclk_q) begin
                     sclk_q <= 1'b0;
                     if (idx_q >= rx_from_q) begin
                        rx_q <= {rx_q[RES_W-2:0], dio_in};
                     end
                     idx_q <= idx_nx;
                     sh_q  <= {sh_q[TX_W-2:0], 1'b0};
                     if (idx_nx == tot_q) begin
                        st_q    <= FE_TAIL;
                        frame_q <= 1'b1;
                        oe_q    <= 1'b0;
                     end else begin
                        oe_q <= (idx_nx < tx_n_q);
                     end
                  end else begin
                     sclk_q <= 1'b1;
                  end
               end
            end
            FE_TAIL: begin
               if (tick) begin
                  st_q    <= FE_IDLE;
                  fdone_q <= 1'b1;
               end
            end
            default: st_q <= FE_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != FE_IDLE);
   assign fdone   = fdone_q;
   assign rx_msb  = rx_q[RES_W-1];
   assign sclk    = sclk_q;
   assign frame_n = frame_q;
   assign dio_out = sh_q[TX_W-1];
   assign dio_oe  = oe_q;
endmodule

// File: rtl/batt_probe_seq.sv
module batt_probe_seq
   import bl_pkg::*;
#(
   parameter int DIV_HALF  = 2,
   parameter int NUM_READS = 3,
   parameter int CONV_CH   = 7,
   parameter int RES_W     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] attr_mask,
   output logic       done,
   output logic       battery_low,
   output logic       sclk_o,
   output logic       frame_n_o,
   output logic       dio_out,
   output logic       dio_oe,
   input  logic       dio_in
);
   if (NUM_READS < 1) begin : g_bad_reads
      $error("batt_probe_seq: NUM_READS must be at least 1");
   end
   if (CONV_CH < 0 || CONV_CH > 7) begin : g_bad_ch
      $error("batt_probe_seq: CONV_CH must lie in 0..7");
   end

   localparam int MW = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;
   localparam logic [MW-1:0] MISS_LAST = MW'(NUM_READS - 1);
   localparam logic [2:0] CH_CODE  = 3'(CONV_CH);
   localparam logic [3:0] MODE_ON  = 4'b0110;
   localparam logic [3:0] MODE_OFF = 4'b0100;
   localparam logic [7:0] CH_BIT   = 8'(1) << CONV_CH;

   sq_state_t   st_q;
   logic [7:0]  attr_q;
   logic [MW-1:0] miss_q;
   logic        low_q;
   logic        done_q;
   logic        launch_q;
   logic        run_q;
   logic        tick_w;
   logic        fe_busy;
   logic        fe_done;
   logic        fe_msb;
   frame_desc_t desc_w;

   assign run_q = (st_q != SQ_IDLE);

   always_comb begin
      desc_w = '0;
      case (st_q)
         SQ_CFG_ON: begin
            desc_w.tx_word = {OP_CTRL, MODE_ON, 4'b0000};
            desc_w.tx_bits = 4'd7;
         end
         SQ_MODE_ON: begin
            desc_w.tx_word = {OP_ATTR, attr_q | CH_BIT};
            desc_w.tx_bits = 4'd11;
         end
         SQ_SAMPLE: begin
            desc_w.tx_word  = {OP_CONV, CH_CODE, 5'b00000};
            desc_w.tx_bits  = 4'd6;
            desc_w.gap_clks = 2'd2;
            desc_w.rx_bits  = 4'(RES_W);
         end
         SQ_CFG_OFF: begin
            desc_w.tx_word = {OP_CTRL, MODE_OFF, 4'b0000};
            desc_w.tx_bits = 4'd7;
         end
         SQ_MODE_OFF: begin
            desc_w.tx_word = {OP_ATTR, attr_q & ~CH_BIT};
            desc_w.tx_bits = 4'd11;
         end
         default: desc_w = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         attr_q   <= '0;
         miss_q   <= '0;
         low_q    <= 1'b0;
         done_q   <= 1'b0;
         launch_q <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         launch_q <= 1'b0;
         if (st_q == SQ_IDLE) begin
            if (go) begin
               attr_q   <= attr_mask;
               low_q    <= 1'b0;
               miss_q   <= '0;
               st_q     <= SQ_CFG_ON;
               launch_q <= 1'b1;
            end
         end else if (fe_done) begin
            case (st_q)
               SQ_CFG_ON: begin
                  st_q     <= SQ_MODE_ON;
                  launch_q <= 1'b1;
               end
               SQ_MODE_ON: begin
                  st_q     <= SQ_SAMPLE;
                  launch_q <= 1'b1;
               end
               SQ_SAMPLE: begin
                  launch_q <= 1'b1;
                  if (fe_msb) begin
                     st_q <= SQ_CFG_OFF;
                  end else if (miss_q == MISS_LAST) begin
                     low_q <= 1'b1;
                     st_q  <= SQ_CFG_OFF;
                  end else begin
                     miss_q <= miss_q + 1'b1;
                  end
               end
               SQ_CFG_OFF: begin
                  st_q     <= SQ_MODE_OFF;
                  launch_q <= 1'b1;
               end
               SQ_MODE_OFF: begin
                  st_q   <= SQ_IDLE;
                  done_q <= 1'b1;
               end
               default: st_q <= SQ_IDLE;
            endcase
         end
      end
   end

   bl_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (fe_busy),
      .tick  (tick_w)
   );

   bl_frame_engine #(.RES_W(RES_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_w),
      .start   (launch_q),
      .desc    (desc_w),
      .busy    (fe_busy),
      .fdone   (fe_done),
      .rx_msb  (fe_msb),
      .sclk    (sclk_o),
      .frame_n (frame_n_o),
      .dio_out (dio_out),
      .dio_oe  (dio_oe),
      .dio_in  (dio_in)
   );

   assign done        = done_q;
   assign battery_low = low_q;
endmodule

// File: rtl/batt_probe_seq_chk.sv
module batt_probe_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic go,
   input logic done,
   input logic battery_low,
   input logic sclk_o,
   input logic frame_n_o,
   input logic dio_oe,
   input logic run_q,
   input logic tick_w
);
   // R2: serial clock idles low outside a frame
   a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n_o |-> !sclk_o);

   // R10: data line released while the strobe is high
   a_r10_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n_o |-> !dio_oe);

   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: done only with the strobe closed
   a_r9_done_closed: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> frame_n_o);

   // R9: flag holds between checks
   a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !go) |=> $stable(battery_low));

   // R11: every serial clock edge follows a divider tick
   a_r11_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk_o) |-> $past(tick_w));
endmodule

bind batt_probe_seq batt_probe_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .go          (go),
   .done        (done),
   .battery_low (battery_low),
   .sclk_o      (sclk_o),
   .frame_n_o   (frame_n_o),
   .dio_oe      (dio_oe),
   .run_q       (run_q),
   .tick_w      (tick_w)
);

// File: tb/batt_probe_seq_bench.sv
module batt_probe_seq_bench;
   localparam int DIVH = 3;
   localparam int NCASE = 5;
   // mask, r0, r1, r2, expected low, expected reads
   localparam logic [39:0] CASES [NCASE] = '{
      {8'h0F, 8'h80, 8'h00, 8'h00, 4'd0, 4'd1},
      {8'h55, 8'h7F, 8'hC3, 8'h00, 4'd0, 4'd2},
      {8'hAA, 8'h10, 8'h20, 8'h7F, 4'd1, 4'd3},
      {8'hFF, 8'h00, 8'h00, 8'h81, 4'd0, 4'd3},
      {8'h00, 8'h7F, 8'h7F, 8'h7F, 4'd1, 4'd3}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       go;
   logic [7:0] attr_mask;
   logic       done, battery_low, sclk_o, frame_n_o, dio_out, dio_oe;
   logic       dio_in;

   batt_probe_seq #(.DIV_HALF(DIVH)) u_batt_probe_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .attr_mask(attr_mask),
      .done(done), .battery_low(battery_low), .sclk_o(sclk_o),
      .frame_n_o(frame_n_o), .dio_out(dio_out), .dio_oe(dio_oe),
      .dio_in(dio_in)
   );

   int checks = 0;
   int failures = 0;

   // converter model: records every frame
   logic [15:0] fbits [64];
   logic [15:0] foe [64];
   int          flen [64];
   int          fcount = 0;
   int          rcnt = 0;
   int          rd_idx = 0;
   int          rd_base = 0;
   logic [7:0]  res_tab [3];
   time         last_rise = 0;
   time         period = 0;
   int          idle_viol = 0;

   always @(posedge sclk_o, posedge frame_n_o) begin
      if (frame_n_o) begin
         if (rcnt > 0) begin
            if (fcount < 64) flen[fcount] = rcnt;
            if (fcount < 64 && fbits[fcount][15:13] == 3'b100) rd_idx++;
            fcount++;
         end
         rcnt = 0;
      end else begin
         period = $time - last_rise;
         last_rise = $time;
         if (fcount < 64) begin
            if (rcnt == 0) begin
               fbits[fcount] = '0;
               foe[fcount] = '0;
            end
            if (rcnt < 16) begin
               fbits[fcount][15-rcnt] = dio_out;
               foe[fcount][15-rcnt] = dio_oe;
            end
         end
         rcnt++;
      end
   end

   always @* begin
      dio_in = 1'b0;
      if (!frame_n_o && fcount < 64 && rcnt >= 9 && rcnt <= 16
          && fbits[fcount][15:13] == 3'b100 && (rd_idx - rd_base) < 3)
         dio_in = res_tab[rd_idx - rd_base][16 - rcnt];
   end

   // R2, R10 monitor: line idle while strobe high
   always @(negedge clk) begin
      if (rst_n && frame_n_o && (sclk_o || dio_oe)) idle_viol++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_go(input logic [7:0] m);
      @(negedge clk);
      go = 1'b1;
      attr_mask = m;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic check_frames(input int base, input logic [7:0] m,
                               input int reads, input logic exp_low);
      chk(fcount - base == 4 + reads, "R6/R7 frame count", fcount - base, 4 + reads);
      chk(battery_low == exp_low, "R6/R7 battery_low", battery_low, exp_low);
      chk(flen[base] == 7 && fbits[base][15:9] == 7'b0110110,
          "R3 control on", fbits[base][15:9], 7'b0110110);
      chk(flen[base+1] == 11 && fbits[base+1][15:5] == {3'b001, 1'b1, m[6:0]},
          "R4 attribute on", fbits[base+1][15:5], {3'b001, 1'b1, m[6:0]});
      for (int k = 0; k < reads; k++) begin
         chk(flen[base+2+k] == 16 && fbits[base+2+k][15:10] == 6'b100111,
             "R5 conversion frame", fbits[base+2+k][15:10], 6'b100111);
         chk(foe[base+2+k] == 16'hFC00, "R10 turnaround", foe[base+2+k], 16'hFC00);
      end
      chk(flen[base+2+reads] == 7 && fbits[base+2+reads][15:9] == 7'b0110100,
          "R8 control off", fbits[base+2+reads][15:9], 7'b0110100);
      chk(flen[base+3+reads] == 11
          && fbits[base+3+reads][15:5] == {3'b001, 1'b0, m[6:0]},
          "R8 attribute off", fbits[base+3+reads][15:5], {3'b001, 1'b0, m[6:0]});
   endtask

   initial begin
      #(200000 * 8);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
   end

   initial begin
      bit seen;
      int base;
      rst_n = 1'b0;
      go = 1'b0;
      attr_mask = '0;
      res_tab[0] = '0; res_tab[1] = '0; res_tab[2] = '0;
      repeat (4) @(negedge clk);
      chk(frame_n_o && !sclk_o && !dio_oe && !done && !battery_low,
          "R1 reset state", {frame_n_o, sclk_o, dio_oe, done, battery_low}, 5'b10000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(frame_n_o && !sclk_o && !dio_oe && !done && !battery_low,
          "R1 after reset", {frame_n_o, sclk_o, dio_oe, done, battery_low}, 5'b10000);

      for (int c = 0; c < NCASE; c++) begin
         base = fcount;
         rd_base = rd_idx;
         res_tab[0] = CASES[c][31:24];
         res_tab[1] = CASES[c][23:16];
         res_tab[2] = CASES[c][15:8];
         pulse_go(CASES[c][39:32]);
         wait_done(seen);
         chk(seen, "R9 done seen", seen, 1);
         @(negedge clk);
         chk(!done, "R9 done one cycle", done, 0);
         check_frames(base, CASES[c][39:32], int'(CASES[c][3:0]), CASES[c][4]);
         repeat (10) @(negedge clk);
         chk(battery_low == CASES[c][4], "R9 flag holds", battery_low, CASES[c][4]);
      end

      chk(period == 2 * DIVH * 8, "R11 sclk period", period, 2 * DIVH * 8);

      // R12: go during a run is ignored
      base = fcount;
      rd_base = rd_idx;
      res_tab[0] = 8'h01; res_tab[1] = 8'h02; res_tab[2] = 8'h03;
      pulse_go(8'h3C);
      repeat (60) @(negedge clk);
      pulse_go(8'h00);
      wait_done(seen);
      chk(seen, "R12 done seen", seen, 1);
      check_frames(base, 8'h3C, 3, 1'b1);
      repeat (200) @(negedge clk);
      chk(fcount - base == 7, "R12 no second run", fcount - base, 7);

      // R9: next go clears a set flag
      base = fcount;
      rd_base = rd_idx;
      res_tab[0] = 8'hFF;
      pulse_go(8'h11);
      @(negedge clk);
      chk(!battery_low, "R9 flag cleared by go", battery_low, 0);
      wait_done(seen);
      check_frames(base, 8'h11, 1, 1'b0);

      chk(idle_viol == 0, "R2/R10 idle lines", idle_viol, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule